// File: doc/BRIEF.md
# Programmable Width Pulse Generator

This block is a clocked one-shot. A rising edge on an asynchronous trigger input produces one output pulse whose length in clock cycles depends linearly on an 8-bit width code. The pulse is driven on two complementary outputs, one true and one inverted. The trigger first passes through a two-flop synchronizer and an edge detector. A fixed start delay then runs before the pulse begins.

The width code is not captured when the trigger arrives. Each cycle of the pulse compares the elapsed count against the length that the code selects at that moment, so changing the code mid-pulse can stretch or cut the pulse. After the pulse there is a recovery window. Trigger edges that arrive during the delay, the pulse or the recovery window are dropped and are not queued. A synchronous active-high reset aborts any activity and parks the outputs at their idle levels.

Top module: `prog_width_oneshot`

## Requirements
- R1: `code_i` is an unsigned 8-bit value. The pulse length in cycles is `BASE_CYC + STEP_CYC * code_i`, which gives 256 settings that rise strictly with the code. With the defaults (2, 1), codes 0, 1, 2, 128 and 255 give 2, 3, 4, 130 and 257 cycles.
- R2: Only a low-to-high change of `trig_i` starts a pulse. A steady high level, or a high-to-low change, starts nothing.
- R3: From idle, `pulse_o` goes high right after the (DELAY_CYC+3)-th rising clock edge that follows `trig_i` going high. This count is two synchronizer stages, one edge register, then DELAY_CYC delay cycles. With the default DELAY_CYC = 3, that is the 6th edge.
- R4: A trigger edge seen during the start delay or during the pulse is ignored. The pulse length is unchanged, and no further pulse follows later.
- R5: After `pulse_o` falls, the block stays in recovery for RECOV_CYC cycles and drops any trigger edge detected there. With RECOV_CYC = 4 and the fall after clock edge F, an edge detected at edge F+4 is dropped and one detected at edge F+5 is accepted.
- R6: `pulse_n_o` is always the exact complement of `pulse_o`.
- R7: While `rst` is high at a clock edge, `pulse_o` is low and `pulse_n_o` is high after that edge. Any pulse in progress is aborted, and the block is idle and accepts the next trigger edge.
- R8: The end of the pulse tracks the live code. If the code is lowered so that the elapsed length reaches or exceeds the new setting, the pulse ends at the next clock edge. For example, if the code is lowered to 3 after 10 high cycles, the pulse is exactly 10 cycles long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Asynchronous trigger; a rising edge requests a pulse |
| code_i | input | 8 | Live width code |
| pulse_o | output | 1 | True output, high during the pulse |
| pulse_n_o | output | 1 | Inverted output, low during the pulse |

## Verification
Two pairs of functions can meet in one cycle. The first is an edge detection and a lockout phase, where the edge must lose. The bench places the rising trigger so that its detection lands on the last recovery edge, where it is dropped, and then one edge later, where it is accepted. The second is the live-code comparison and the running count: the bench lowers the code after exactly ten high samples and checks that the measured width is ten, with no extra cycle.

// File: rtl/pwo_pkg.sv
package pwo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_PULSE = 2'd2,
        ST_RECOV = 2'd3
    } pwo_state_t;

    typedef struct packed {
        pwo_state_t st;
        logic       busy;
    } pwo_phase_t;

    function automatic int unsigned pwo_max3(input int unsigned a,
                                             input int unsigned b,
                                             input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int unsigned pwo_longest(input int unsigned base,
                                                input int unsigned step,
                                                input int unsigned code_bits);
        return base + step * ((1 << code_bits) - 1);
    endfunction

endpackage

// File: rtl/pwo_edge_sync.sv
module pwo_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    localparam int STAGES = 2;

    logic [STAGES-1:0] sync_q;
    logic              hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            hist_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            hist_q <= sync_q[STAGES-1];
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~hist_q;

    // R2: a detected edge lasts exactly one cycle
    a_r2_single_cycle_rise: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pwo_timer.sv
module pwo_timer
    import pwo_pkg::*;
#(
    parameter int unsigned CODE_W    = 8,
    parameter int unsigned BASE_CYC  = 2,
    parameter int unsigned STEP_CYC  = 1,
    parameter int unsigned DELAY_CYC = 3,
    parameter int unsigned RECOV_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              fire_next_o
);
    localparam int unsigned LONGEST = pwo_longest(BASE_CYC, STEP_CYC, CODE_W);
    localparam int unsigned CNT_W   = $clog2(pwo_max3(LONGEST, DELAY_CYC, RECOV_CYC) + 2);

    pwo_phase_t       ph_q, ph_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] target;
    logic             len_hit;

    always_comb begin
        target  = CNT_W'(BASE_CYC) + CNT_W'(STEP_CYC) * CNT_W'(code_i);
        len_hit = (cnt_q + 1'b1) >= target;
    end

    always_comb begin
        ph_d  = ph_q;
        cnt_d = cnt_q + 1'b1;
        unique case (ph_q.st)
            ST_IDLE: begin
                cnt_d = '0;
                if (rise_i) ph_d = '{st: ST_DELAY, busy: 1'b1};
            end
            ST_DELAY: begin
                if (cnt_q == CNT_W'(DELAY_CYC - 1)) begin
                    ph_d  = '{st: ST_PULSE, busy: 1'b1};
                    cnt_d = '0;
                end
            end
            ST_PULSE: begin
                if (len_hit) begin
                    ph_d  = '{st: ST_RECOV, busy: 1'b1};
                    cnt_d = '0;
                end
            end
            ST_RECOV: begin
                if (cnt_q == CNT_W'(RECOV_CYC - 1)) begin
                    ph_d  = '{st: ST_IDLE, busy: 1'b0};
                    cnt_d = '0;
                end
            end
            default: begin
                ph_d  = '{st: ST_IDLE, busy: 1'b0};
                cnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= '{st: ST_IDLE, busy: 1'b0};
            cnt_q <= '0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
        end
    end

    assign fire_next_o = (ph_d.st == ST_PULSE) && !rst;

    // R3: a pulse is always preceded by the start delay
    a_r3_no_skip_delay: assert property (@(posedge clk) disable iff (rst)
        (ph_q.st == ST_IDLE) |=> (ph_q.st == ST_IDLE || ph_q.st == ST_DELAY));

    // R4: no new start while delaying or pulsing
    a_r4_busy_ignores: assert property (@(posedge clk) disable iff (rst)
        (ph_q.st == ST_PULSE) |=> (ph_q.st == ST_PULSE || ph_q.st == ST_RECOV));

    // R5: recovery never restarts directly
    a_r5_recov_lock: assert property (@(posedge clk) disable iff (rst)
        (ph_q.st == ST_RECOV) |=> (ph_q.st != ST_DELAY && ph_q.st != ST_PULSE));

    // R8: reaching the live length ends the pulse on the next edge
    a_r8_live_end: assert property (@(posedge clk) disable iff (rst)
        (ph_q.st == ST_PULSE && len_hit) |=> (ph_q.st == ST_RECOV));

    // R1: length counter stays within the longest setting
    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        (ph_q.st == ST_PULSE) |-> (cnt_q < CNT_W'(LONGEST)));

endmodule

// File: rtl/pwo_out_stage.sv
module pwo_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic fire_next_i,
    output logic pulse_o,
    output logic pulse_n_o
);
    logic true_q, inv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            true_q <= 1'b0;
            inv_q  <= 1'b1;
        end else begin
            true_q <= fire_next_i;
            inv_q  <= !fire_next_i;
        end
    end

    assign pulse_o   = true_q;
    assign pulse_n_o = inv_q;

    // R6: the two output flops stay complementary
    a_r6_complement: assert property (@(posedge clk) disable iff (rst)
        pulse_n_o == !pulse_o);

    // R7: reset parks the outputs at idle levels
    a_r7_reset_idle: assert property (@(posedge clk)
        rst |=> (!pulse_o && pulse_n_o));

endmodule

// File: rtl/prog_width_oneshot.sv
module prog_width_oneshot
    import pwo_pkg::*;
#(
    parameter int unsigned CODE_W    = 8,
    parameter int unsigned BASE_CYC  = 2,
    parameter int unsigned STEP_CYC  = 1,
    parameter int unsigned DELAY_CYC = 3,
    parameter int unsigned RECOV_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              pulse_o,
    output logic              pulse_n_o
);
    logic rise;
    logic fire_next;

    pwo_edge_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (trig_i),
        .rise_o  (rise)
    );

    pwo_timer #(
        .CODE_W    (CODE_W),
        .BASE_CYC  (BASE_CYC),
        .STEP_CYC  (STEP_CYC),
        .DELAY_CYC (DELAY_CYC),
        .RECOV_CYC (RECOV_CYC)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .rise_i      (rise),
        .code_i      (code_i),
        .fire_next_o (fire_next)
    );

    pwo_out_stage u_out (
        .clk         (clk),
        .rst         (rst),
        .fire_next_i (fire_next),
        .pulse_o     (pulse_o),
        .pulse_n_o   (pulse_n_o)
    );

endmodule

// File: tb/prog_width_oneshot_tb.sv
module prog_width_oneshot_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BASE  = 2;
    localparam int STEP  = 1;
    localparam int DLY   = 3;
    localparam int RCV   = 4;
    localparam int NVEC  = 5;
    localparam int VEC_CODE [NVEC] = '{0, 1, 2, 128, 255};
    localparam int VEC_LEN  [NVEC] = '{2, 3, 4, 130, 257};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       trig = 1'b0;
    logic [7:0] code = 8'd0;
    logic       pulse, pulse_n;

    int n_chk = 0;
    int n_bad = 0;
    int meas_delay, meas_len;
    bit comp_ok;

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_width_oneshot u_dut (
        .clk       (clk),
        .rst       (rst),
        .trig_i    (trig),
        .code_i    (code),
        .pulse_o   (pulse),
        .pulse_n_o (pulse_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // mode 0: plain; 1: retrigger at sample 5; 2: lower code to 3 at sample 10; 3: hold trigger high
    task automatic fire(input int mode);
        int guard;
        meas_delay = 0;
        meas_len   = 0;
        comp_ok    = 1'b1;
        @(negedge clk);
        trig = 1'b1;
        guard = 0;
        do begin
            @(negedge clk);
            meas_delay++;
            guard++;
        end while (!pulse && guard < 60);
        if (mode != 3) trig = 1'b0;
        while (pulse && meas_len < 400) begin
            meas_len++;
            if (pulse_n !== !pulse) comp_ok = 1'b0;
            if (mode == 1 && meas_len == 3) trig = 1'b1;
            if (mode == 1 && meas_len == 5) trig = 1'b0;
            if (mode == 2 && meas_len == 10) code = 8'd3;
            @(negedge clk);
        end
        if (pulse_n !== 1'b1) comp_ok = 1'b0;
    endtask

    task automatic quiet(input int cycles, input string tag);
        int highs = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pulse) highs++;
        end
        chk(highs == 0, tag, highs, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(pulse == 1'b0 && pulse_n == 1'b1, "R7 reset levels", {pulse, pulse_n}, 2'b01);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1/R3/R6: width table
        for (int v = 0; v < NVEC; v++) begin
            code = 8'(VEC_CODE[v]);
            fire(0);
            chk(meas_delay == DLY + 3, "R3 start delay", meas_delay, DLY + 3);
            chk(meas_len == VEC_LEN[v], "R1 width", meas_len, VEC_LEN[v]);
            chk(meas_len == BASE + STEP * VEC_CODE[v], "R1 formula", meas_len, BASE + STEP * VEC_CODE[v]);
            chk(comp_ok, "R6 complement", comp_ok, 1);
            repeat (RCV + 3) @(negedge clk);
        end

        // R4: retrigger mid-pulse ignored
        code = 8'd20;
        fire(1);
        chk(meas_len == 22, "R4 retrigger width", meas_len, 22);
        quiet(40, "R4 no queued pulse");

        // R2: held level and falling edge start nothing
        code = 8'd5;
        fire(3);
        chk(meas_len == 7, "R2 held width", meas_len, 7);
        quiet(30, "R2 level held");
        trig = 1'b0;
        quiet(30, "R2 falling edge");

        // R8: live code shortens the pulse
        code = 8'd255;
        fire(2);
        chk(meas_len == 10, "R8 live cut", meas_len, 10);
        repeat (RCV + 3) @(negedge clk);

        // R5: edge detected on last recovery edge is dropped
        code = 8'd4;
        fire(0);
        @(negedge clk);
        trig = 1'b1;
        quiet(30, "R5 drop in recovery");
        trig = 1'b0;
        repeat (5) @(negedge clk);

        // R5: edge detected on first idle edge is accepted
        fire(0);
        repeat (RCV - 2) @(negedge clk);
        trig = 1'b1;
        begin
            int seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (pulse) seen = 1;
            end
            chk(seen == 1, "R5 accept after recovery", seen, 1);
        end
        trig = 1'b0;
        repeat (20) @(negedge clk);

        // R7: reset aborts a pulse and leaves the block ready
        code = 8'd100;
        @(negedge clk);
        trig = 1'b1;
        repeat (12) @(negedge clk);
        trig = 1'b0;
        chk(pulse == 1'b1, "R7 pulse running", pulse, 1);
        rst = 1'b1;
        @(negedge clk);
        chk(pulse == 1'b0 && pulse_n == 1'b1, "R7 abort", {pulse, pulse_n}, 2'b01);
        rst = 1'b0;
        quiet(10, "R7 stays idle");
        code = 8'd1;
        fire(0);
        chk(meas_len == 3 && meas_delay == DLY + 3, "R7 ready after reset", meas_len, 3);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule